// File: doc/BRIEF.md
# Serial Shifter with Trailing-Bit Masking

This block is a byte-oriented synchronous serial transmitter. Software-side logic writes words into a single holding register. The shifter moves each word out most significant bit first, one bit for every shift-clock tick. The serial clock pulses low for one clock after each bit that is actually sent.

A stream of whole words can only be a multiple of eight bits long. To allow a stream of any length, a word can be written as the final word with trimming armed. A small prescaler then counts the bits of that word that really go out. When the count reaches the keep value stored with the word, the block raises a mask indicator. Every later bit of that word is forced to the idle level and gets no clock pulse.

At the end of a telegram, when the last bit has gone out and no further word is waiting, the block can raise a one-cycle transmit-empty interrupt. An interrupt enable gates this pulse. A halt input stops the whole block and clears its state.

Top module: `ser_mask_tx`

## Requirements
- R1: On each `tick` while a word is loaded, the next bit (MSB first) appears on `ser_data` after that clock edge. `ser_clk` is low for the clock after each sent bit and high otherwise.
- R2: After reset, and in the clock after any cycle with `halt`=1, `ser_data`=1, `ser_clk`=1, `trim_active`=0 and `tx_irq`=0. A write made while `halt`=1 is ignored and sends nothing.
- R3: A written word is taken into the shifter on the next edge if the shifter is idle. If a word is waiting when the current word's eighth bit goes out, it is taken on that same edge with no gap.
- R4: Trimming is armed for a word only if `wr_trim_off`=0 when it is written. `wr_keep` is captured together with the word.
- R5: For an armed word, sent bits are counted from 0. On the tick where the count equals the keep value, that bit and every later bit of the word are blanked: `ser_data`=1 with no `ser_clk` pulse. `trim_active` goes to 1 after that tick.
- R6: A keep value of 0 blanks the whole armed word. A keep value of 8 to 15 sends all eight bits.
- R7: `trim_active` and the count clear when the next word is taken into the shifter, or when `halt` is 1.
- R8: When the eighth bit of a word goes out, no word is waiting and no write occurs in that cycle, `tx_irq` is 1 for exactly the following clock if `irq_en`=1. Otherwise `tx_irq` stays 0.
- R9: Ticks with no word loaded change neither `ser_clk` nor the state.
- R10: A write while a word is already waiting replaces the waiting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | 1 stops the block and clears its state |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send |
| wr_keep | input | CNT_W | Number of bits to keep in an armed word |
| wr_trim_off | input | 1 | 0 arms trimming for this word |
| tick | input | 1 | Shift-clock enable, one bit per pulse |
| irq_en | input | 1 | Interrupt enable |
| ser_data | output | 1 | Serial data, idle high |
| ser_clk | output | 1 | Serial clock, low pulse per sent bit |
| tx_irq | output | 1 | Transmit-empty interrupt pulse |
| trim_active | output | 1 | Mask indicator for trailing bits |

## Verification
A wrong bit position or a slipped prescaler count shows up on `ser_data` and `ser_clk` in the clock right after the tick concerned. The bench therefore compares every bit slot, not just whole words. A mask flag that is left set, or a holding flag that is lost, shows up on the first tick of the next word or telegram: clock pulses are missing, a word is skipped, or the interrupt is wrong at the end of that telegram. A halt that does not fully clear state shows up one clock after the halt, as a non-idle output or a stuck `trim_active`.

// File: rtl/smt_pkg.sv
package smt_pkg;
  parameter int unsigned TX_W  = 8;
  parameter int unsigned KEEP_W = 4;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  wr_keep,
  input  logic              wr_trim_off,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_armed,
  output logic [CNT_W-1:0]  hold_keep
);

  // Occupancy flag; a write in the same cycle as a take refills it.
  always_ff @(posedge clk) begin
    if (rst || !act) begin
      full <= 1'b0;
    end else if (wr) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // Payload needs no reset: it is only read while full is set.
  always_ff @(posedge clk) begin
    if (act && wr) begin
      hold_data  <= wr_data;
      hold_armed <= ~wr_trim_off;
      hold_keep  <= wr_keep;
    end
  end

  a_r10_write_fills : assert property (@(posedge clk) disable iff (rst)
    (act && wr) |=> full);

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             load,
  input  logic             load_armed,
  input  logic [CNT_W-1:0] load_keep,
  input  logic             step,
  output logic             blank,
  output logic             mask_q
);

  logic             armed_q;
  logic [CNT_W-1:0] keep_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit   = armed_q && (cnt_q == keep_q);
  assign blank = mask_q || hit;

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      armed_q <= 1'b0;
      keep_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= 1'b0;
    end else if (load) begin
      armed_q <= load_armed;
      keep_q  <= load_keep;
      cnt_q   <= '0;
      mask_q  <= 1'b0;
    end else if (step && armed_q) begin
      if (blank) begin
        mask_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R5: the count of sent bits never passes the word width.
  a_r5_count_bound : assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DATA_W));

  // R7: the mask cannot survive a load.
  a_r7_load_clears : assert property (@(posedge clk) disable iff (rst)
    (act && load) |=> !mask_q);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import smt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              blank,
  output logic              take,
  output logic              word_done,
  output logic              busy,
  output logic              sd,
  output logic              sc
);

  localparam int unsigned POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W - 1);

  sh_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [POS_W-1:0]  pos;

  assign busy      = (state == SH_BUSY);
  assign word_done = busy && tick && (pos == LAST_POS);
  assign take      = act && hold_full && (!busy || word_done);

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      state <= SH_IDLE;
      shreg <= '0;
      pos   <= '0;
      sd    <= 1'b1;
      sc    <= 1'b1;
    end else begin
      sc <= 1'b1;
      if (busy && tick) begin
        sd    <= blank ? 1'b1 : shreg[DATA_W-1];
        sc    <= blank;
        shreg <= shreg << 1;
        pos   <= pos + POS_W'(1);
        if (word_done) begin
          state <= SH_IDLE;
        end
      end
      if (take) begin
        shreg <= hold_data;
        pos   <= '0;
        state <= SH_BUSY;
      end
    end
  end

  // R1: a clock pulse only ever follows a tick.
  a_r1_pulse_after_tick : assert property (@(posedge clk) disable iff (rst)
    !sc |-> $past(tick));

  // R9: an idle shifter never produces a clock pulse.
  a_r9_idle_quiet : assert property (@(posedge clk) disable iff (rst)
    (!busy && act) |=> sc);

endmodule

// File: rtl/ser_mask_tx.sv
module ser_mask_tx #(
  parameter int unsigned DATA_W = smt_pkg::TX_W,
  parameter int unsigned CNT_W  = smt_pkg::KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  wr_keep,
  input  logic              wr_trim_off,
  input  logic              tick,
  input  logic              irq_en,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              tx_irq,
  output logic              trim_active
);

  logic              act;
  logic              take;
  logic              word_done;
  logic              busy;
  logic              blank;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_armed;
  logic [CNT_W-1:0]  hold_keep;

  assign act = ~halt;

  tx_hold #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .wr         (wr_en),
    .wr_data    (wr_data),
    .wr_keep    (wr_keep),
    .wr_trim_off(wr_trim_off),
    .take       (take),
    .full       (hold_full),
    .hold_data  (hold_data),
    .hold_armed (hold_armed),
    .hold_keep  (hold_keep)
  );

  trim_prescaler #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_trim (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .load      (take),
    .load_armed(hold_armed),
    .load_keep (hold_keep),
    .step      (busy && tick),
    .blank     (blank),
    .mask_q    (trim_active)
  );

  tx_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .tick     (tick),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .blank    (blank),
    .take     (take),
    .word_done(word_done),
    .busy     (busy),
    .sd       (ser_data),
    .sc       (ser_clk)
  );

  // End of telegram: last bit out and nothing queued behind it.
  always_ff @(posedge clk) begin
    if (rst || halt) begin
      tx_irq <= 1'b0;
    end else begin
      tx_irq <= irq_en && word_done && !hold_full && !wr_en;
    end
  end

  a_r2_halt_idle : assert property (@(posedge clk) disable iff (rst)
    halt |=> (ser_data && ser_clk && !trim_active && !tx_irq));

  a_r5_mask_quiet : assert property (@(posedge clk) disable iff (rst)
    trim_active |-> (ser_clk && ser_data));

  a_r8_irq_gated : assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(irq_en));

  a_r8_irq_single : assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

endmodule

// File: tb/ser_mask_tx_tb.sv
module ser_mask_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] wr_keep = '0;
  logic       wr_trim_off = 1'b1;
  logic       tick = 1'b0;
  logic       irq_en = 1'b0;
  logic       ser_data;
  logic       ser_clk;
  logic       tx_irq;
  logic       trim_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ser_mask_tx u_dut (
    .clk        (clk),
    .rst        (rst),
    .halt       (halt),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_keep    (wr_keep),
    .wr_trim_off(wr_trim_off),
    .tick       (tick),
    .irq_en     (irq_en),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .tx_irq     (tx_irq),
    .trim_active(trim_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bit_sent(input bit armed, input logic [3:0] keep, input int k);
    return !armed || (k < int'(keep));
  endfunction

  function automatic bit mask_after(input bit armed, input logic [3:0] keep, input int k);
    return armed && (int'(keep) <= k);
  endfunction

  // Drives a one-cycle write; returns at the negedge after the capturing edge.
  task automatic put_word(input logic [7:0] w, input logic [3:0] keep, input bit trim_off);
    wr_en = 1'b1; wr_data = w; wr_keep = keep; wr_trim_off = trim_off;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Eight ticks with a gap cycle after each; checks every bit slot.
  task automatic run_word(input logic [7:0] w, input bit armed, input logic [3:0] keep,
                          input bit chained, input bit last, input bit ie);
    for (int k = 0; k < 8; k++) begin
      bit s;
      s = bit_sent(armed, keep, k);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      check("R1 data bit", ser_data, s ? w[7-k] : 1'b1);
      check("R5 clock pulse", ser_clk, s ? 1'b0 : 1'b1);
      check("R7 mask flag", trim_active, (k == 7 && chained) ? 1'b0 : mask_after(armed, keep, k));
      check("R8 irq at end", tx_irq, (k == 7 && last && ie) ? 1'b1 : 1'b0);
      @(negedge clk);
      check("R1 clock idle", ser_clk, 1'b1);
      check("R8 irq pulse width", tx_irq, 1'b0);
    end
  endtask

  task automatic telegram(input int n, input logic [7:0] w[3], input bit arm[3],
                          input logic [3:0] keep[3], input bit ie);
    irq_en = ie;
    put_word(w[0], keep[0], !arm[0]);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i + 1 < n) put_word(w[i+1], keep[i+1], !arm[i+1]);
      run_word(w[i], arm[i], keep[i], i + 1 < n, i == n - 1, ie);
    end
  endtask

  task automatic one_word(input logic [7:0] w, input bit arm, input logic [3:0] keep, input bit ie);
    logic [7:0] wa[3];
    bit         aa[3];
    logic [3:0] ka[3];
    wa = '{w, 8'h00, 8'h00};
    aa = '{arm, 1'b0, 1'b0};
    ka = '{keep, 4'd0, 4'd0};
    telegram(1, wa, aa, ka, ie);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hang expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    logic [7:0] wa[3];
    bit         aa[3];
    logic [3:0] ka[3];
    seed_val = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check("R2 reset data", ser_data, 1'b1);
    check("R2 reset clk", ser_clk, 1'b1);
    check("R2 reset mask", trim_active, 1'b0);
    check("R2 reset irq", tx_irq, 1'b0);

    // R1/R8: plain word, interrupt on
    one_word(8'hA5, 1'b0, 4'd3, 1'b1);
    // R5: armed, keep 3
    one_word(8'h5A, 1'b1, 4'd3, 1'b1);
    // R6: keep 0, 8, 15
    one_word(8'h00, 1'b1, 4'd0, 1'b1);
    one_word(8'h3C, 1'b1, 4'd8, 1'b1);
    one_word(8'hC3, 1'b1, 4'd15, 1'b0);
    // R4: trim off at write leaves word whole
    one_word(8'h81, 1'b0, 4'd2, 1'b1);
    // R8: interrupt disabled
    one_word(8'h7E, 1'b0, 4'd0, 1'b0);

    // R3/R7: chained words, mask cleared by the load of the next word
    wa = '{8'h96, 8'h0F, 8'hE1};
    aa = '{1'b1, 1'b1, 1'b0};
    ka = '{4'd7, 4'd5, 4'd0};
    telegram(3, wa, aa, ka, 1'b1);

    // R9: ticks with nothing loaded
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R9 idle tick clk", ser_clk, 1'b1);
      check("R9 idle tick irq", tx_irq, 1'b0);
    end

    // R2: write during halt is ignored
    halt = 1'b1;
    put_word(8'h00, 4'd8, 1'b1);
    halt = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R2 halted write clk", ser_clk, 1'b1);
      check("R2 halted write data", ser_data, 1'b1);
    end

    // R2/R7: halt in the middle of an armed word
    irq_en = 1'b1;
    put_word(8'hFF, 4'd1, 1'b0);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    check("R5 mask set before halt", trim_active, 1'b1);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check("R7 halt clears mask", trim_active, 1'b0);
    check("R2 halt idle data", ser_data, 1'b1);
    check("R2 halt idle clk", ser_clk, 1'b1);
    for (int k = 0; k < 6; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R2 halt dropped word clk", ser_clk, 1'b1);
      check("R2 halt dropped word irq", tx_irq, 1'b0);
    end

    // R10: overwrite of the waiting word
    irq_en = 1'b1;
    put_word(8'h11, 4'd8, 1'b1);
    @(negedge clk);
    put_word(8'h22, 4'd8, 1'b1);
    put_word(8'hB4, 4'd4, 1'b0);
    run_word(8'h11, 1'b0, 4'd8, 1'b1, 1'b0, 1'b1);
    run_word(8'hB4, 1'b1, 4'd4, 1'b0, 1'b1, 1'b1);

    // Random telegrams
    for (int t = 0; t < 40; t++) begin
      int n;
      bit ie;
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < 3; i++) begin
        wa[i] = 8'($urandom);
        aa[i] = 1'($urandom);
        ka[i] = 4'($urandom);
      end
      ie = 1'($urandom);
      telegram(n, wa, aa, ka, ie);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule